// File: doc/BRIEF.md
# Keypad Scancode Scanner

This block sits between a keyboard byte receiver and a calculator's line buffer. Each received byte arrives with a one-cycle strobe. The block tracks the break (0xF0) and extended (0xE0) prefix bytes. It acts only when a key is released. For the calculator subset of keys, it issues one of three handshaked requests:

- a character hand-off, carrying an ASCII byte;
- a backspace request;
- an evaluate request to the expression evaluator.

All other codes are dropped without any output.

The controller is a four-state machine:

- **ST_IDLE** waits for a key code. Transitions out of it:
  - **go_take**: a released character key moves to ST_TAKE.
  - **go_bksp**: a released backspace moves to ST_BKSP.
  - **go_eval**: a released enter moves to ST_EVAL.
  - **stay_drop**: a make code, a prefix byte, or an unlisted code keeps the machine in ST_IDLE.
- **ST_TAKE** returns to ST_IDLE on **take_done** (the buffer's done line is high).
- **ST_BKSP** returns to ST_IDLE on **bksp_done** (the buffer's done line is high).
- **ST_EVAL** returns to ST_IDLE on **eval_done** (the evaluator's finished line is high).

While any request is pending, every received byte is discarded, including prefix bytes.

Top module: `kps_scanner`

## Requirements
- R1: After the active-low synchronous reset, `chr_take`, `bksp_req` and `eval_go` are low.
- R2: A release sequence for a character key makes `chr_take` high in the cycle after the key byte's strobe. At the same time, `chr_out` carries the ASCII code for the key. The release sequence is 0xF0 followed by the key code. The mapping is:
  - keypad 0..9 = 0x70,0x69,0x72,0x7A,0x6B,0x73,0x74,0x6C,0x75,0x7D map to '0'..'9';
  - 0x79 maps to '+';
  - 0x7B maps to '-';
  - 0x7C maps to '*';
  - 0x29 maps to 0x20.
- R3: `chr_take` and `chr_out` stay unchanged until `buf_done` is sampled high. `chr_take` is low from the cycle after that sample.
- R4: Releasing code 0x66 raises `bksp_req`. It uses the same `buf_done` handshake as R3.
- R5: Releasing enter raises `eval_go`. Enter is 0x5A, with or without a preceding 0xE0. `eval_go` stays high for however long it takes until `eval_finished` is sampled high, and is low from the cycle after that sample.
- R6: The sequence 0xE0 0xF0 0x4A (keypad divide) yields '/'. A lone 0xE0 produces no output.
- R7: A key code with no preceding 0xF0 (a make code) produces no output.
- R8: A released code outside the listed set produces no output. With the 0xE0 prefix, only 0x4A and 0x5A are accepted.
- R9: Bytes received while a request is pending are ignored, including 0xF0. After the request completes, a lone key code produces nothing.
- R10: At most one of `chr_take`, `bksp_req` and `eval_go` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_strobe | input | 1 | One-cycle pulse marking a new received byte |
| rx_byte | input | 8 | Received byte |
| buf_done | input | 1 | Line buffer has accepted a character or backspace |
| eval_finished | input | 1 | Evaluator has finished |
| chr_take | output | 1 | Character hand-off request |
| chr_out | output | 8 | ASCII character, valid while `chr_take` is high |
| bksp_req | output | 1 | Backspace request |
| eval_go | output | 1 | Evaluate request |

## Verification
The bench drives random mixes of make and release sequences, with and without the extended prefix, drawn from accepted and rejected codes. It compares the results against a key table written in the bench.

Directed cases target specific mistakes:
- An extended non-keypad code (0xE0 0xF0 0x70) must not be treated as keypad 0. A design that drops the extended flag would emit '0'.
- A break prefix sent during a pending handshake must not arm the next code. A design that accepts it would turn a later make code into a phantom keystroke.
- An evaluator that takes many cycles must not cause `eval_go` to drop early.
- Random response delays check that `chr_out` does not change before `buf_done`.

// File: rtl/kps_pkg.sv
package kps_pkg;
    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_CHAR,
        KIND_BKSP,
        KIND_ENTER
    } key_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAKE,
        ST_BKSP,
        ST_EVAL
    } scan_state_t;
endpackage

// File: rtl/kps_prefix.sv
module kps_prefix #(
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  BRK_CODE = 8'hF0,
    parameter logic [7:0]  EXT_CODE = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              brk_seen,
    output logic              ext_seen,
    output logic              key_strobe
);
    logic is_brk, is_ext;

    always_comb begin
        is_brk     = (byte_in == BYTE_W'(BRK_CODE));
        is_ext     = (byte_in == BYTE_W'(EXT_CODE));
        key_strobe = accept && !is_brk && !is_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_seen <= 1'b0;
            ext_seen <= 1'b0;
        end else if (accept) begin
            if (is_brk) begin
                brk_seen <= 1'b1;
            end else if (is_ext) begin
                ext_seen <= 1'b1;
            end else begin
                brk_seen <= 1'b0;
                ext_seen <= 1'b0;
            end
        end
    end

    // R7: any key byte consumes both prefix flags
    a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> (!brk_seen && !ext_seen));
endmodule

// File: rtl/kps_decode.sv
module kps_decode
    import kps_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] code,
    input  logic              ext,
    output key_kind_t         kind,
    output logic [BYTE_W-1:0] ascii
);
    always_comb begin
        kind  = KIND_NONE;
        ascii = '0;
        if (ext) begin
            unique case (code)
                BYTE_W'(8'h4A): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h2F); end
                BYTE_W'(8'h5A): kind = KIND_ENTER;
                default: ;
            endcase
        end else begin
            unique case (code)
                BYTE_W'(8'h70): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h30); end
                BYTE_W'(8'h69): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h31); end
                BYTE_W'(8'h72): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h32); end
                BYTE_W'(8'h7A): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h33); end
                BYTE_W'(8'h6B): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h34); end
                BYTE_W'(8'h73): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h35); end
                BYTE_W'(8'h74): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h36); end
                BYTE_W'(8'h6C): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h37); end
                BYTE_W'(8'h75): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h38); end
                BYTE_W'(8'h7D): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h39); end
                BYTE_W'(8'h79): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h2B); end
                BYTE_W'(8'h7B): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h2D); end
                BYTE_W'(8'h7C): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h2A); end
                BYTE_W'(8'h29): begin kind = KIND_CHAR; ascii = BYTE_W'(8'h20); end
                BYTE_W'(8'h66): kind = KIND_BKSP;
                BYTE_W'(8'h5A): kind = KIND_ENTER;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner
    import kps_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter logic [7:0] BRK_CODE = 8'hF0,
    parameter logic [7:0] EXT_CODE = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              buf_done,
    input  logic              eval_finished,
    output logic              chr_take,
    output logic [BYTE_W-1:0] chr_out,
    output logic              bksp_req,
    output logic              eval_go
);
    scan_state_t       state, nxt;
    logic              accept, brk_seen, ext_seen, key_strobe, release_key;
    key_kind_t         kind;
    logic [BYTE_W-1:0] ascii, chr_q;

    assign accept      = rx_strobe && (state == ST_IDLE);
    assign release_key = key_strobe && brk_seen;

    kps_prefix #(.BYTE_W(BYTE_W), .BRK_CODE(BRK_CODE), .EXT_CODE(EXT_CODE)) u_prefix (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .byte_in    (rx_byte),
        .brk_seen   (brk_seen),
        .ext_seen   (ext_seen),
        .key_strobe (key_strobe)
    );

    kps_decode #(.BYTE_W(BYTE_W)) u_decode (
        .code  (rx_byte),
        .ext   (ext_seen),
        .kind  (kind),
        .ascii (ascii)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (release_key) begin
                    unique case (kind)
                        KIND_CHAR:  nxt = ST_TAKE;   // go_take
                        KIND_BKSP:  nxt = ST_BKSP;   // go_bksp
                        KIND_ENTER: nxt = ST_EVAL;   // go_eval
                        default:    nxt = ST_IDLE;   // stay_drop
                    endcase
                end
            end
            ST_TAKE: if (buf_done)      nxt = ST_IDLE;  // take_done
            ST_BKSP: if (buf_done)      nxt = ST_IDLE;  // bksp_done
            ST_EVAL: if (eval_finished) nxt = ST_IDLE;  // eval_done
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            chr_q <= '0;
        end else begin
            state <= nxt;
            if (release_key && kind == KIND_CHAR) chr_q <= ascii;
        end
    end

    always_comb begin
        chr_take = (state == ST_TAKE);
        bksp_req = (state == ST_BKSP);
        eval_go  = (state == ST_EVAL);
        chr_out  = chr_q;
    end

    // R10: requests are mutually exclusive
    a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chr_take, bksp_req, eval_go}));
    // R3: character request and data held until done
    a_r3_take_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_take && !buf_done) |=> (chr_take && $stable(chr_out)));
    // R3: request dropped after done
    a_r3_take_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_take && buf_done) |=> !chr_take);
    // R4: backspace held until done
    a_r4_bksp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bksp_req && !buf_done) |=> bksp_req);
    // R5: evaluate held until finished, then dropped
    a_r5_eval_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && !eval_finished) |=> eval_go);
    a_r5_eval_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && eval_finished) |=> !eval_go);
    // R7: a make code raises nothing
    a_r7_make_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (key_strobe && !brk_seen) |=> !(chr_take || bksp_req || eval_go));
    // R9: a pending request is not displaced by incoming bytes
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && chr_take && !buf_done) |=> (chr_take && $stable(chr_out)));
endmodule

// File: tb/kps_scanner_tb.sv
module kps_scanner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       buf_done = 1'b0;
    logic       eval_finished = 1'b0;
    logic       chr_take, bksp_req, eval_go;
    logic [7:0] chr_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    kps_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .buf_done(buf_done), .eval_finished(eval_finished),
        .chr_take(chr_take), .chr_out(chr_out), .bksp_req(bksp_req), .eval_go(eval_go)
    );

    // expected kind: 0 none, 1 char, 2 backspace, 3 enter; ascii in low byte
    function automatic logic [9:0] expect_key(input logic [7:0] c, input bit ext);
        if (ext) begin
            if (c == 8'h4A) return {2'd1, 8'h2F};
            if (c == 8'h5A) return {2'd3, 8'h00};
            return 10'd0;
        end
        case (c)
            8'h70: return {2'd1, "0"};  8'h69: return {2'd1, "1"};
            8'h72: return {2'd1, "2"};  8'h7A: return {2'd1, "3"};
            8'h6B: return {2'd1, "4"};  8'h73: return {2'd1, "5"};
            8'h74: return {2'd1, "6"};  8'h6C: return {2'd1, "7"};
            8'h75: return {2'd1, "8"};  8'h7D: return {2'd1, "9"};
            8'h79: return {2'd1, "+"};  8'h7B: return {2'd1, "-"};
            8'h7C: return {2'd1, "*"};  8'h29: return {2'd1, " "};
            8'h66: return {2'd2, 8'h00};
            8'h5A: return {2'd3, 8'h00};
            default: return 10'd0;
        endcase
    endfunction

    function automatic logic [7:0] pool(input int i);
        case (i % 22)
            0: return 8'h70;  1: return 8'h69;  2: return 8'h72;  3: return 8'h7A;
            4: return 8'h6B;  5: return 8'h73;  6: return 8'h74;  7: return 8'h6C;
            8: return 8'h75;  9: return 8'h7D; 10: return 8'h79; 11: return 8'h7B;
            12: return 8'h7C; 13: return 8'h29; 14: return 8'h66; 15: return 8'h5A;
            16: return 8'h4A; 17: return 8'h1C; 18: return 8'h45; 19: return 8'h12;
            20: return 8'h76; default: return 8'h0D;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_strobe = 1'b1; rx_byte = b;
        @(negedge clk); rx_strobe = 1'b0;
    endtask

    task automatic send_key(input logic [7:0] c, input bit ext, input bit rel);
        if (ext) send_byte(8'hE0);
        if (rel) send_byte(8'hF0);
        send_byte(c);
    endtask

    task automatic check_idle(input string req);
        check({chr_take, bksp_req, eval_go} == 3'b000, req, {chr_take, bksp_req, eval_go}, 3'b000);
    endtask

    // called at the negedge after the key byte was sampled
    task automatic resolve(input logic [9:0] exp, input int delay, input bit inject);
        logic [2:0] want;
        string tag;
        case (exp[9:8])
            2'd1: begin want = 3'b100; tag = "R2"; end
            2'd2: begin want = 3'b010; tag = "R4"; end
            2'd3: begin want = 3'b001; tag = "R5"; end
            default: begin want = 3'b000; tag = "R8"; end
        endcase
        check({chr_take, bksp_req, eval_go} == want, tag, {chr_take, bksp_req, eval_go}, want);
        if (want == 3'b100) check(chr_out == exp[7:0], "R2", chr_out, exp[7:0]);
        if (want == 3'b000) return;
        for (int k = 0; k < delay; k++) begin
            if (inject && k == 0) begin
                rx_strobe = 1'b1; rx_byte = 8'hF0;
            end else if (inject && k == 1) begin
                rx_strobe = 1'b1; rx_byte = pool(k + delay);
            end else begin
                rx_strobe = 1'b0;
            end
            @(negedge clk);
            check({chr_take, bksp_req, eval_go} == want, inject ? "R9" : "R3", {chr_take, bksp_req, eval_go}, want);
            if (want == 3'b100) check(chr_out == exp[7:0], "R3", chr_out, exp[7:0]);
        end
        rx_strobe = 1'b0;
        if (want == 3'b001) eval_finished = 1'b1; else buf_done = 1'b1;
        @(negedge clk);
        buf_done = 1'b0; eval_finished = 1'b0;
        check({chr_take, bksp_req, eval_go} == 3'b000, want == 3'b001 ? "R5" : "R3",
              {chr_take, bksp_req, eval_go}, 3'b000);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done_flag) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R2 every character key in turn
        for (int i = 0; i < 14; i++) begin
            send_key(pool(i), 1'b0, 1'b1);
            resolve(expect_key(pool(i), 1'b0), i % 3, 1'b0);
        end
        // R4 backspace
        send_key(8'h66, 1'b0, 1'b1);
        resolve(expect_key(8'h66, 1'b0), 2, 1'b0);
        // R5 long evaluation, plain and extended enter
        send_key(8'h5A, 1'b0, 1'b1);
        resolve(expect_key(8'h5A, 1'b0), 60, 1'b0);
        send_key(8'h5A, 1'b1, 1'b1);
        resolve(expect_key(8'h5A, 1'b1), 5, 1'b0);
        // R6 divide, lone extended prefix
        send_key(8'h4A, 1'b1, 1'b1);
        check(chr_out == 8'h2F, "R6", chr_out, 8'h2F);
        resolve(expect_key(8'h4A, 1'b1), 1, 1'b0);
        send_byte(8'hE0);
        check_idle("R6");
        send_byte(8'hF0);
        send_byte(8'h70);
        check_idle("R8 extended 0x70");
        // R7 make code
        send_key(8'h70, 1'b0, 1'b0);
        check_idle("R7");
        // R8 unlisted release
        send_key(8'h1C, 1'b0, 1'b1);
        check_idle("R8");
        // R9 break byte during pending, then lone make code
        send_key(8'h69, 1'b0, 1'b1);
        resolve(expect_key(8'h69, 1'b0), 3, 1'b1);
        send_byte(8'h72);
        check_idle("R9");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] c;
            bit ext, rel, inj;
            int dly;
            c   = pool($urandom_range(0, 21));
            ext = ($urandom_range(0, 3) == 0);
            rel = ($urandom_range(0, 3) != 0);
            inj = ($urandom_range(0, 2) == 0);
            dly = $urandom_range(2, 12);
            send_key(c, ext, rel);
            if (!rel) check_idle("R7");
            else resolve(expect_key(c, ext), dly, inj);
            check_idle("R10");
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule